// File: doc/BRIEF.md
# Thread Block Admission Controller

This controller sits in front of one multiprocessor and decides, one block at a time and strictly in arrival order, whether a thread block can start there. A launch request carries the number of threads in the block and the registers each thread needs. The block is admitted only if three budgets still hold once it is added: a free resident-block slot, the resident-thread ceiling and a contiguous range in the shared register pool. An admitted block receives a slot number, the base of a register range that belongs to it alone, and the number of warps it splits into.

The controller tracks every resident block in a slot table. A completion notice names a slot, and the controller then returns that block's threads and registers. Free register ranges are kept as an address-sorted list. Allocation takes the lowest-addressed range that is large enough. A returned range is merged with any free neighbour, so the pool never stays fragmented after its blocks finish. A request that could never fit is answered at once with an error flag instead of waiting forever.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After reset no response is pending, all slots are idle, no threads are counted and the whole pool of 8192 registers is free, so the first valid request is admitted to slot 0 with register base 0.
- R2: At most 8 blocks are resident. A further request stalls with req_ready low until a slot is released.
- R3: The resident thread total never exceeds 768. A request whose threads would push the total past 768 stalls.
- R4: A block needs threads × registers-per-thread registers as one contiguous range. If no free range is large enough, the request stalls.
- R5: rsp_warps equals the thread count divided by 32, rounded up. It is 0 on an error response.
- R6: An admitted block gets the lowest-numbered idle slot.
- R7: The register base is the lowest address at which the needed range fits without touching any range held by a resident block. Ranges of resident blocks never overlap.
- R8: A completion returns the slot, its threads and its registers. A freed range is merged with adjacent free ranges, so a later block can use the combined space.
- R9: A request with zero threads, zero registers per thread, more than 768 threads or more than 8192 registers is accepted at once with rsp_error high, rsp_slot 0, rsp_reg_base 0 and rsp_warps 0. It consumes nothing.
- R10: In a cycle with done_valid high, req_ready is low. The request is taken no earlier than the next cycle, and it then sees the freed resources.
- R11: A completion notice naming an idle slot is ignored.
- R12: A response is registered. It appears the cycle after acceptance and holds with stable fields while rsp_ready is low, and no new request is accepted meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request taken this cycle (admit or reject) |
| req_threads | input | 11 | Threads in the block |
| req_regs | input | 8 | Registers per thread |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_slot | output | 3 | Slot given to the block |
| rsp_reg_base | output | 13 | First register of the block's range |
| rsp_warps | output | 5 | Warps created for the block |
| rsp_error | output | 1 | Request could never be admitted |
| done_valid | input | 1 | Block completion notice |
| done_slot | input | 3 | Slot of the completed block |

## Verification
A corrupted free list or slot table shows at the ports on the next admission that depends on it. The wrong register base or slot number comes out one cycle after acceptance, or req_ready has the wrong level in the very cycle the request is presented. Thread-count drift appears as a wrongly admitted or wrongly stalled block at the 768 boundary. A lost merge appears only later, when a block sized to the combined gap stalls. The stimulus therefore places requests exactly at each limit right after releases.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  localparam int DEF_MAX_BLOCKS  = 8;
  localparam int DEF_MAX_THREADS = 768;
  localparam int DEF_REG_POOL    = 8192;
  localparam int DEF_WARP_SIZE   = 32;
  localparam int DEF_REQ_THR_W   = 11;
  localparam int DEF_RPT_W       = 8;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/blk_admit_calc.sv
// Admission arithmetic: register demand, warp count, hopeless-request flag.
module blk_admit_calc
  import blk_admit_pkg::*;
#(
  parameter int MAX_THREADS = DEF_MAX_THREADS,
  parameter int REG_POOL    = DEF_REG_POOL,
  parameter int WARP_SIZE   = DEF_WARP_SIZE,
  parameter int REQ_THR_W   = DEF_REQ_THR_W,
  parameter int RPT_W       = DEF_RPT_W,
  localparam int NEED_W     = REQ_THR_W + RPT_W,
  localparam int SUM_W      = REQ_THR_W + 1,
  localparam int WARP_W     = $clog2(ceil_div(MAX_THREADS, WARP_SIZE) + 1)
) (
  input  logic [REQ_THR_W-1:0] threads,
  input  logic [RPT_W-1:0]     regs,
  output logic [NEED_W-1:0]    need,
  output logic [WARP_W-1:0]    warps,
  output logic                 bad
);

  logic [SUM_W-1:0] rounded;

  always_comb begin
    need    = NEED_W'(threads) * NEED_W'(regs);
    bad     = (threads == '0) || (regs == '0) ||
              (SUM_W'(threads) > SUM_W'(MAX_THREADS)) ||
              (need > NEED_W'(REG_POOL));
    rounded = (SUM_W'(threads) + SUM_W'(WARP_SIZE - 1)) / SUM_W'(WARP_SIZE);
    warps   = bad ? '0 : WARP_W'(rounded);
  end

endmodule

// File: rtl/blk_slot_table.sv
// Resident-block table: busy flags, register range and thread count per slot.
module blk_slot_table #(
  parameter int N      = 8,
  parameter int LEN_W  = 14,
  parameter int THR_W  = 10,
  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [LEN_W-1:0]  alloc_base,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic [THR_W-1:0]  alloc_thr,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_idx,
  input  logic [SLOT_W-1:0] q_slot,
  output logic              q_busy,
  output logic [LEN_W-1:0]  q_base,
  output logic [LEN_W-1:0]  q_len,
  output logic [THR_W-1:0]  q_thr,
  input  logic              rel_en,
  output logic [LEN_W-1:0]  held_total
);

  logic [N-1:0]            busy_q;
  logic [N-1:0][LEN_W-1:0] base_q;
  logic [N-1:0][LEN_W-1:0] len_q;
  logic [N-1:0][THR_W-1:0] thr_q;

  // lowest idle slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  // lookup of the slot named by a completion
  always_comb begin
    q_busy = 1'b0;
    q_base = '0;
    q_len  = '0;
    q_thr  = '0;
    for (int i = 0; i < N; i++) begin
      if (q_slot == SLOT_W'(i)) begin
        q_busy = busy_q[i];
        q_base = base_q[i];
        q_len  = len_q[i];
        q_thr  = thr_q[i];
      end
    end
  end

  always_comb begin
    held_total = '0;
    for (int i = 0; i < N; i++)
      if (busy_q[i]) held_total = held_total + len_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      base_q <= '0;
      len_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (rel_en && q_busy) busy_q[q_slot] <= 1'b0;
      if (alloc_en) begin
        busy_q[free_idx] <= 1'b1;
        base_q[free_idx] <= alloc_base;
        len_q[free_idx]  <= alloc_len;
        thr_q[free_idx]  <= alloc_thr;
      end
    end
  end

  AST_ALLOC_HAS_SLOT: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> free_any);  // R2
  AST_RELEASE_BUSY_ONLY: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> q_busy);  // R11
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !alloc_en) |=> !busy_q[$past(q_slot)]);  // R8

endmodule

// File: rtl/blk_reg_pool.sv
// Free register ranges kept sorted by base; first-fit take, merging give-back.
module blk_reg_pool #(
  parameter int POOL    = 8192,
  parameter int ENTRIES = 9,
  localparam int LEN_W  = $clog2(POOL + 1),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] alloc_len,
  output logic             fit,
  output logic [LEN_W-1:0] fit_base,
  input  logic             alloc_en,
  input  logic             rel_en,
  input  logic [LEN_W-1:0] rel_base,
  input  logic [LEN_W-1:0] rel_len,
  output logic [LEN_W-1:0] free_total
);

  logic [ENTRIES-1:0][LEN_W-1:0] fb_q, fl_q, nb, nl;
  logic [ENTRIES-1:0][LEN_W-1:0] up_b, up_l, dn_b, dn_l;
  logic [CNT_W-1:0]              cnt_q, ncnt;

  // neighbour views for shifting the list one place either way
  for (genvar g = 0; g < ENTRIES; g++) begin : g_nbr
    if (g < ENTRIES - 1) begin : g_up
      assign up_b[g] = fb_q[g+1];
      assign up_l[g] = fl_q[g+1];
    end else begin : g_up_end
      assign up_b[g] = '0;
      assign up_l[g] = '0;
    end
    if (g > 0) begin : g_dn
      assign dn_b[g] = fb_q[g-1];
      assign dn_l[g] = fl_q[g-1];
    end else begin : g_dn_end
      assign dn_b[g] = '0;
      assign dn_l[g] = '0;
    end
  end

  // first-fit search
  logic [CNT_W-1:0] hit_idx;
  logic [LEN_W-1:0] hit_len;
  always_comb begin
    fit      = 1'b0;
    hit_idx  = '0;
    hit_len  = '0;
    fit_base = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < cnt_q) && (fl_q[i] >= alloc_len)) begin
        fit      = 1'b1;
        hit_idx  = CNT_W'(i);
        hit_len  = fl_q[i];
        fit_base = fb_q[i];
      end
    end
  end

  // insertion point and merge tests for a give-back
  logic [CNT_W-1:0] pos;
  logic [LEN_W-1:0] prv_b, prv_l, nxt_b, nxt_l;
  logic             mrg_prv, mrg_nxt;
  always_comb begin
    pos   = '0;
    prv_b = '0;
    prv_l = '0;
    nxt_b = '0;
    nxt_l = '0;
    for (int i = 0; i < ENTRIES; i++)
      if ((CNT_W'(i) < cnt_q) && (fb_q[i] < rel_base)) pos = pos + 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (CNT_W'(i + 1) == pos) begin
        prv_b = fb_q[i];
        prv_l = fl_q[i];
      end
      if (CNT_W'(i) == pos) begin
        nxt_b = fb_q[i];
        nxt_l = fl_q[i];
      end
    end
    mrg_prv = (pos != '0) && (prv_b + prv_l == rel_base);
    mrg_nxt = (pos < cnt_q) && (rel_base + rel_len == nxt_b);
  end

  // next list contents
  always_comb begin
    nb   = fb_q;
    nl   = fl_q;
    ncnt = cnt_q;
    if (alloc_en && fit) begin
      if (hit_len == alloc_len) begin
        ncnt = cnt_q - 1'b1;
        for (int i = 0; i < ENTRIES; i++)
          if (CNT_W'(i) >= hit_idx) begin
            nb[i] = up_b[i];
            nl[i] = up_l[i];
          end
      end else begin
        for (int i = 0; i < ENTRIES; i++)
          if (CNT_W'(i) == hit_idx) begin
            nb[i] = fb_q[i] + alloc_len;
            nl[i] = fl_q[i] - alloc_len;
          end
      end
    end else if (rel_en) begin
      if (mrg_prv && mrg_nxt) begin
        ncnt = cnt_q - 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (CNT_W'(i + 1) == pos) nl[i] = fl_q[i] + rel_len + nxt_l;
          else if (CNT_W'(i) >= pos) begin
            nb[i] = up_b[i];
            nl[i] = up_l[i];
          end
        end
      end else if (mrg_prv) begin
        for (int i = 0; i < ENTRIES; i++)
          if (CNT_W'(i + 1) == pos) nl[i] = fl_q[i] + rel_len;
      end else if (mrg_nxt) begin
        for (int i = 0; i < ENTRIES; i++)
          if (CNT_W'(i) == pos) begin
            nb[i] = rel_base;
            nl[i] = fl_q[i] + rel_len;
          end
      end else begin
        ncnt = cnt_q + 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (CNT_W'(i) == pos) begin
            nb[i] = rel_base;
            nl[i] = rel_len;
          end else if (CNT_W'(i) > pos) begin
            nb[i] = dn_b[i];
            nl[i] = dn_l[i];
          end
        end
      end
    end
  end

  always_comb begin
    free_total = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (CNT_W'(i) < cnt_q) free_total = free_total + fl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q    <= '0;
      fl_q    <= '0;
      fl_q[0] <= LEN_W'(POOL);
      cnt_q   <= CNT_W'(1);
    end else begin
      fb_q  <= nb;
      fl_q  <= nl;
      cnt_q <= ncnt;
    end
  end

  AST_ALLOC_FITS: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> fit);  // R4
  AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !(alloc_en && rel_en));  // R10
  AST_LIST_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(ENTRIES));  // R8

endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import blk_admit_pkg::*;
#(
  parameter int MAX_BLOCKS  = DEF_MAX_BLOCKS,
  parameter int MAX_THREADS = DEF_MAX_THREADS,
  parameter int REG_POOL    = DEF_REG_POOL,
  parameter int WARP_SIZE   = DEF_WARP_SIZE,
  parameter int REQ_THR_W   = DEF_REQ_THR_W,
  parameter int RPT_W       = DEF_RPT_W,
  localparam int SLOT_W     = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BASE_W     = $clog2(REG_POOL),
  localparam int WARP_W     = $clog2(ceil_div(MAX_THREADS, WARP_SIZE) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_THR_W-1:0] req_threads,
  input  logic [RPT_W-1:0]  req_regs,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [SLOT_W-1:0] rsp_slot,
  output logic [BASE_W-1:0] rsp_reg_base,
  output logic [WARP_W-1:0] rsp_warps,
  output logic              rsp_error,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot
);

  localparam int LEN_W  = $clog2(REG_POOL + 1);
  localparam int THR_W  = $clog2(MAX_THREADS + 1);
  localparam int NEED_W = REQ_THR_W + RPT_W;
  localparam int SUM_W  = REQ_THR_W + 1;
  localparam int FL_N   = MAX_BLOCKS + 1;

  logic [NEED_W-1:0] need;
  logic [WARP_W-1:0] warps;
  logic              bad;

  blk_admit_calc #(
    .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL), .WARP_SIZE(WARP_SIZE),
    .REQ_THR_W(REQ_THR_W), .RPT_W(RPT_W)
  ) u_calc (
    .threads(req_threads), .regs(req_regs), .need(need), .warps(warps), .bad(bad)
  );

  logic              free_any, q_busy, pool_fit, admit, accept, rel_do, hold;
  logic [SLOT_W-1:0] free_idx;
  logic [LEN_W-1:0]  q_base, q_len, pool_base, free_total, held_total;
  logic [THR_W-1:0]  q_thr, thr_used_q;
  logic [SUM_W-1:0]  thr_sum;

  blk_slot_table #(.N(MAX_BLOCKS), .LEN_W(LEN_W), .THR_W(THR_W)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_en(admit), .alloc_base(pool_base), .alloc_len(LEN_W'(need)),
    .alloc_thr(THR_W'(req_threads)),
    .free_any(free_any), .free_idx(free_idx),
    .q_slot(done_slot), .q_busy(q_busy), .q_base(q_base), .q_len(q_len), .q_thr(q_thr),
    .rel_en(rel_do), .held_total(held_total)
  );

  blk_reg_pool #(.POOL(REG_POOL), .ENTRIES(FL_N)) u_pool (
    .clk(clk), .rst(rst),
    .alloc_len(LEN_W'(need)), .fit(pool_fit), .fit_base(pool_base),
    .alloc_en(admit), .rel_en(rel_do), .rel_base(q_base), .rel_len(q_len),
    .free_total(free_total)
  );

  logic              rsp_valid_q, rsp_err_q;
  logic [SLOT_W-1:0] rsp_slot_q;
  logic [BASE_W-1:0] rsp_base_q;
  logic [WARP_W-1:0] rsp_warps_q;

  always_comb begin
    thr_sum   = SUM_W'(thr_used_q) + SUM_W'(req_threads);
    hold      = rsp_valid_q && !rsp_ready;
    rel_do    = done_valid && q_busy;
    // release-first: a completion cycle takes no request
    req_ready = !hold && !done_valid &&
                (bad || (free_any && (thr_sum <= SUM_W'(MAX_THREADS)) && pool_fit));
    accept    = req_valid && req_ready;
    admit     = accept && !bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_used_q <= '0;
    end else if (admit) begin
      thr_used_q <= thr_used_q + THR_W'(req_threads);
    end else if (rel_do) begin
      thr_used_q <= thr_used_q - q_thr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_slot_q  <= '0;
      rsp_base_q  <= '0;
      rsp_warps_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= bad;
      rsp_slot_q  <= bad ? '0 : free_idx;
      rsp_base_q  <= bad ? '0 : pool_base[BASE_W-1:0];
      rsp_warps_q <= warps;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_error    = rsp_err_q;
  assign rsp_slot     = rsp_slot_q;
  assign rsp_reg_base = rsp_base_q;
  assign rsp_warps    = rsp_warps_q;

  AST_THREAD_CAP: assert property (@(posedge clk) disable iff (rst)
    thr_used_q <= THR_W'(MAX_THREADS));  // R3
  AST_POOL_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (free_total + held_total) == LEN_W'(REG_POOL));  // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_slot) &&
     $stable(rsp_reg_base) && $stable(rsp_warps) && $stable(rsp_error)));  // R12
  AST_ERR_TAKES_NOTHING: assert property (@(posedge clk) disable iff (rst)
    (accept && bad) |=> $stable(thr_used_q));  // R9

endmodule

// File: tb/blk_admit_ctrl_tb.sv
module blk_admit_ctrl_tb_top;

  localparam int NB = 8, MT = 768, RP = 8192, WS = 32;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [10:0] req_threads = '0;
  logic [7:0]  req_regs = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_error;
  logic [2:0]  rsp_slot;
  logic [12:0] rsp_reg_base;
  logic [4:0]  rsp_warps;
  logic        done_valid = 1'b0;
  logic [2:0]  done_slot = '0;

  always #4 clk = ~clk;

  blk_admit_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_slot(rsp_slot), .rsp_reg_base(rsp_reg_base),
    .rsp_warps(rsp_warps), .rsp_error(rsp_error), .done_valid(done_valid),
    .done_slot(done_slot)
  );

  int n_chk = 0, n_err = 0;
  bit m_busy [NB];
  int m_base [NB];
  int m_size [NB];
  int m_thr  [NB];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_bad(int t, int r);
    return (t == 0) || (r == 0) || (t > MT) || (t * r > RP);
  endfunction

  function automatic int m_slot();
    for (int i = 0; i < NB; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int m_thr_sum();
    int s = 0;
    for (int i = 0; i < NB; i++) if (m_busy[i]) s += m_thr[i];
    return s;
  endfunction

  // lowest address where the range fits between held ranges
  function automatic int m_first_fit(int need);
    int best = -1;
    for (int c = -1; c < NB; c++) begin
      int cand;
      bit ok;
      if (c < 0) cand = 0;
      else if (m_busy[c]) cand = m_base[c] + m_size[c];
      else continue;
      ok = (cand + need <= RP);
      for (int j = 0; j < NB; j++)
        if (m_busy[j] && cand < m_base[j] + m_size[j] && m_base[j] < cand + need) ok = 0;
      if (ok && (best < 0 || cand < best)) best = cand;
    end
    return best;
  endfunction

  task automatic do_req(int t, int r, string tag);
    bit bd = m_bad(t, r);
    int sl = m_slot();
    int ff = m_first_fit(t * r);
    bit rdy = bd || (sl >= 0 && m_thr_sum() + t <= MT && ff >= 0);
    @(negedge clk);
    req_valid = 1'b1; req_threads = 11'(t); req_regs = 8'(r);
    #1 chk({tag, " ready"}, int'(req_ready), int'(rdy));
    @(negedge clk);
    if (rdy) begin
      req_valid = 1'b0;
      #1;
      chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
      chk({tag, " R9 error"}, int'(rsp_error), int'(bd));
      chk({tag, " R5 warps"}, int'(rsp_warps), bd ? 0 : (t + WS - 1) / WS);
      chk({tag, " R6 slot"}, int'(rsp_slot), bd ? 0 : sl);
      chk({tag, " R7 base"}, int'(rsp_reg_base), bd ? 0 : ff);
      if (!bd) begin
        m_busy[sl] = 1'b1; m_base[sl] = ff; m_size[sl] = t * r; m_thr[sl] = t;
      end
    end else begin
      #1 chk({tag, " still stalled"}, int'(req_ready), 0);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_done(int s);
    @(negedge clk);
    done_valid = 1'b1; done_slot = 3'(s);
    @(negedge clk);
    done_valid = 1'b0;
    m_busy[s] = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NB; i++) if (m_busy[i]) do_done(i);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) begin
      m_busy[i] = 0; m_base[i] = 0; m_size[i] = 0; m_thr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk("R1 no response after reset", int'(rsp_valid), 0);
    do_req(1, 1, "R1 first block");
    clear_all();

    // warp rounding R5
    do_req(32, 1, "R5 exact warp");
    do_req(33, 1, "R5 one extra");
    do_req(1, 2, "R5 single thread");
    clear_all();

    // thread and register limits R3 R4
    do_req(256, 10, "R3 fill a");
    do_req(256, 10, "R3 fill b");
    do_req(256, 10, "R3 fill c");
    do_req(1, 1, "R3 over thread cap");
    do_done(1);
    do_req(256, 11, "R4 gap too small");
    do_req(256, 10, "R4 exact gap reuse");
    clear_all();

    // merge on release R8
    for (int k = 0; k < 4; k++) do_req(64, 32, "R8 quarter");
    do_req(1, 1, "R4 pool full");
    do_done(1);
    do_done(2);
    do_req(64, 64, "R8 merged gap");
    clear_all();

    // error requests R9
    do_req(0, 5, "R9 zero threads");
    do_req(10, 0, "R9 zero regs");
    do_req(769, 1, "R9 too many threads");
    do_req(512, 17, "R9 too many regs");
    do_req(768, 10, "R9 nothing consumed");
    clear_all();

    // slot limit R2
    for (int k = 0; k < NB; k++) do_req(32, 1, "R2 fill slots");
    do_req(1, 1, "R2 ninth stalls");

    // release-first R10
    @(negedge clk);
    done_valid = 1'b1; done_slot = 3'd4;
    req_valid = 1'b1; req_threads = 11'd32; req_regs = 8'd1;
    #1 chk("R10 blocked during release", int'(req_ready), 0);
    @(negedge clk);
    done_valid = 1'b0; m_busy[4] = 1'b0;
    #1 chk("R10 ready next cycle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk("R10 freed slot", int'(rsp_slot), 4);
    chk("R10 freed base", int'(rsp_reg_base), 128);
    m_busy[4] = 1'b1;
    clear_all();

    // idle completion ignored R11 (thread cap full, slot 5 idle)
    do_req(256, 1, "R11 fill a");
    do_req(256, 1, "R11 fill b");
    do_req(256, 1, "R11 fill c");
    @(negedge clk);
    done_valid = 1'b1; done_slot = 3'd5;
    @(negedge clk);
    done_valid = 1'b0;
    do_req(1, 1, "R11 cap unchanged");
    clear_all();

    // response hold R12
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_threads = 11'd40; req_regs = 8'd3;
    #1 chk("R12 first ready", int'(req_ready), 1);
    @(negedge clk);
    req_threads = 11'd1; req_regs = 8'd1;
    #1 chk("R12 no accept while held", int'(req_ready), 0);
    @(negedge clk);
    #1 chk("R12 valid held", int'(rsp_valid), 1);
    chk("R12 slot stable", int'(rsp_slot), 0);
    chk("R12 warps stable", int'(rsp_warps), 2);
    chk("R12 still blocked", int'(req_ready), 0);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    m_busy[0] = 1'b1; m_base[0] = 0; m_size[0] = 120; m_thr[0] = 40;
    @(negedge clk);
    #1 chk("R12 consumed", int'(rsp_valid), 0);
    clear_all();

    // constrained random mix against the model
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 10) < 6) begin
        int t = (($urandom % 12) == 0) ? 700 + int'($urandom % 100) : 1 + int'($urandom % 300);
        do_req(t, 1 + int'($urandom % 24), "R7 random");
      end else begin
        do_done(int'($urandom % NB));
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule